// File: doc/BRIEF.md
# PS/2 Device-Side Emulator

This block takes the place of a PS/2 keyboard or mouse inside the chip. Bytes to be sent arrive on a valid/ready byte stream, typically fed by a UART receiver. Each byte leaves as an 11-bit device-to-host frame on an internal clock/data pair. A one-cycle parallel strobe carrying the same byte marks the start of each frame.

Host-to-device frames come in on a second clock/data pair and are decoded there. The block answers them on its own. It acknowledges every command, reruns its start-up sequence on a reset command and replays the last byte on a resend command. It also copies every well-formed command byte to a byte port, so a UART transmitter can forward it. Commands that arrive while a frame is going out wait in a small queue until that frame ends.

The mode input selects keyboard or mouse behaviour. The only difference between the two modes is the identity byte sent during start-up.

Top module: `ps2_dev_emu`

## Requirements
- R1: Each device frame has 11 bits: a start bit of 0, eight data bits least significant bit first, an odd parity bit, and a stop bit of 1. Each bit lasts BIT_CYC clock cycles. The clock is high for the first half of a bit and low for the second half. Data changes only while the clock is high and is stable at every falling edge. Both lines idle high.
- R2: During reset both device lines are high, and no strobe, command or ready is raised. After reset is released, 0xAA is the first byte sent. In keyboard mode (mode_mouse_i = 0) nothing follows it. In mouse mode (mode_mouse_i = 1) 0x00 follows it.
- R3: A stream byte is taken when in_valid_i and in_ready_o are both high at a clock edge. Stream bytes are sent in order. One cycle after a byte is taken, tx_strobe_o pulses with tx_byte_o equal to that byte, and the start bit appears in the same cycle. Every frame, of any origin, gets such a strobe.
- R4: Every well-formed host command is answered with 0xFA before anything else. A command other than 0xFF or 0xFE gets only 0xFA.
- R5: Host command 0xFF is answered with 0xFA, then 0xAA, then 0x00 if the block is in mouse mode.
- R6: Host command 0xFE is answered with 0xFA, then the stored last byte. Only stream bytes, 0xAA and the 0x00 identity byte update the stored byte. The 0xFA acknowledge, the 0xFE error reply and the replayed byte never update it.
- R7: A host frame is received with a bad parity bit (parity must be odd over data and parity), a start bit of 1 or a stop bit of 0. Such a frame is answered with 0xFE alone and never appears on the command port.
- R8: Each well-formed host frame raises cmd_valid_o for exactly one cycle, with cmd_data_o holding its data byte.
- R9: A host command that completes while a frame is being sent is held until that frame ends. Its reply then goes out before any further stream byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_mouse_i | input | 1 | 1 selects mouse behaviour, 0 selects keyboard |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Stream byte accepted at this edge when valid is also high |
| host_clk_i | input | 1 | Host-to-device clock line (asynchronous) |
| host_dat_i | input | 1 | Host-to-device data line, sampled on host clock falling edges |
| dev_clk_o | output | 1 | Device-to-host clock line |
| dev_dat_o | output | 1 | Device-to-host data line |
| tx_strobe_o | output | 1 | One-cycle pulse at the start of each device frame |
| tx_byte_o | output | 8 | Byte of the frame being started |
| cmd_valid_o | output | 1 | One-cycle pulse for each well-formed host command |
| cmd_data_o | output | 8 | Host command byte |

## Verification
A host command can finish decoding while a stream byte is being framed. In the same window a second stream byte is already waiting with its valid high. Both then compete for the one idle cycle after the frame ends. The bench provokes this by sending a host command shortly after a stream byte has been taken, with the next stream byte held valid. It judges the outcome from the decoded device line: the acknowledge must come between the two stream bytes. A reset or resend command sets off a chain of reply bytes, so the bench also checks that this chain keeps its order and that the replayed byte is unaffected by the replies sent around it.

// File: rtl/ps2_emu_pkg.sv
package ps2_emu_pkg;
  localparam logic [7:0] BYTE_ACK    = 8'hFA;
  localparam logic [7:0] BYTE_RESEND = 8'hFE;
  localparam logic [7:0] BYTE_RESET  = 8'hFF;
  localparam logic [7:0] BYTE_INIT   = 8'hAA;
  localparam logic [7:0] BYTE_ID     = 8'h00;
  localparam int unsigned FRAME_BITS = 11;

  // queued host command: error flag and byte
  typedef struct packed {
    logic       err;
    logic [7:0] data;
  } cmd_entry_t;
endpackage

// File: rtl/ps2_tx_framer.sv
module ps2_tx_framer #(
  parameter int unsigned BIT_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       dev_clk_o,
  output logic       dev_dat_o
);
  import ps2_emu_pkg::*;
  localparam int unsigned CW   = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int unsigned HALF = BIT_CYC / 2;
  localparam logic [3:0]  LAST_BIT = 4'(FRAME_BITS - 1);

  logic          busy_q;
  logic [3:0]    bit_q;
  logic [CW-1:0] cnt_q;
  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '1;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        bit_q  <= '0;
        cnt_q  <= '0;
        sh_q   <= {1'b1, ~^data_i, data_i, 1'b0};
      end
    end else if (cnt_q == CW'(BIT_CYC - 1)) begin
      cnt_q <= '0;
      sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
      if (bit_q == LAST_BIT) busy_q <= 1'b0;
      else                   bit_q  <= bit_q + 4'd1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign busy_o    = busy_q;
  // clock high in first half of a bit, low in second; data moves with the high phase
  assign dev_clk_o = !(busy_q && (cnt_q >= CW'(HALF)));
  assign dev_dat_o = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_clk_i,
  input  logic       host_dat_i,
  output logic       valid_o,
  output logic       err_o,
  output logic [7:0] data_o
);
  import ps2_emu_pkg::*;
  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic       c1_q, c2_q, cprev_q, d1_q, d2_q;
  logic [3:0] cnt_q;
  logic [9:0] sh_q;
  logic       fall, frame_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= 1'b1; c2_q <= 1'b1; cprev_q <= 1'b1;
      d1_q <= 1'b1; d2_q <= 1'b1;
    end else begin
      c1_q <= host_clk_i; c2_q <= c1_q; cprev_q <= c2_q;
      d1_q <= host_dat_i; d2_q <= d1_q;
    end
  end

  assign fall     = cprev_q & ~c2_q;
  // sh_q[0] start, sh_q[8:1] data, sh_q[9] parity, d2_q stop
  assign frame_ok = !sh_q[0] && d2_q && (^sh_q[9:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (fall) begin
        if (cnt_q == LAST_BIT) begin
          cnt_q   <= '0;
          valid_o <= frame_ok;
          err_o   <= !frame_ok;
          data_o  <= sh_q[8:1];
        end else begin
          cnt_q <= cnt_q + 4'd1;
          sh_q  <= {d2_q, sh_q[9:1]};
        end
      end
    end
  end
endmodule

// File: rtl/ps2_cmd_fifo.sv
module ps2_cmd_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wr_q, rd_q;

  assign empty_o = (wr_q == rd_q);
  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i && !full_o) wr_q <= wr_q + 1'b1;
      if (pop_i && !empty_o) rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/ps2_dev_emu.sv
module ps2_dev_emu #(
  parameter int unsigned BIT_CYC   = 16,
  parameter int unsigned CMD_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_mouse_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  input  logic       host_clk_i,
  input  logic       host_dat_i,
  output logic       dev_clk_o,
  output logic       dev_dat_o,
  output logic       tx_strobe_o,
  output logic [7:0] tx_byte_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_data_o
);
  import ps2_emu_pkg::*;

  logic       rx_valid, rx_err;
  logic [7:0] rx_data;
  cmd_entry_t q_in, q_out;
  logic       q_empty, q_full, q_pop;
  logic       tx_busy, tx_start;
  logic [7:0] tx_data;

  // reply flags, sent in priority order ack > err > init > id > replay
  logic pend_ack_q, pend_err_q, pend_aa_q, pend_id_q, pend_rep_q;
  logic pend_ack_d, pend_err_d, pend_aa_d, pend_id_d, pend_rep_d;
  logic [7:0] last_q, last_d;
  logic       any_pend;

  ps2_host_rx i_rx (
    .clk_i, .rst_ni, .host_clk_i, .host_dat_i,
    .valid_o(rx_valid), .err_o(rx_err), .data_o(rx_data)
  );

  assign q_in = '{err: rx_err, data: rx_data};

  ps2_cmd_fifo #(.WIDTH($bits(cmd_entry_t)), .DEPTH(CMD_DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_valid || rx_err),
    .data_i (q_in),
    .pop_i  (q_pop),
    .data_o (q_out),
    .empty_o(q_empty),
    .full_o (q_full)
  );

  ps2_tx_framer #(.BIT_CYC(BIT_CYC)) i_tx (
    .clk_i, .rst_ni,
    .start_i  (tx_start),
    .data_i   (tx_data),
    .busy_o   (tx_busy),
    .dev_clk_o(dev_clk_o),
    .dev_dat_o(dev_dat_o)
  );

  assign any_pend   = pend_ack_q | pend_err_q | pend_aa_q | pend_id_q | pend_rep_q;
  assign in_ready_o = rst_ni && !tx_busy && !any_pend && q_empty;

  always_comb begin
    pend_ack_d = pend_ack_q;
    pend_err_d = pend_err_q;
    pend_aa_d  = pend_aa_q;
    pend_id_d  = pend_id_q;
    pend_rep_d = pend_rep_q;
    last_d     = last_q;
    tx_start   = 1'b0;
    tx_data    = last_q;
    q_pop      = 1'b0;
    if (!tx_busy) begin
      if (pend_ack_q) begin
        tx_start = 1'b1; tx_data = BYTE_ACK; pend_ack_d = 1'b0;
      end else if (pend_err_q) begin
        tx_start = 1'b1; tx_data = BYTE_RESEND; pend_err_d = 1'b0;
      end else if (pend_aa_q) begin
        tx_start = 1'b1; tx_data = BYTE_INIT; pend_aa_d = 1'b0;
        pend_id_d = mode_mouse_i; last_d = BYTE_INIT;
      end else if (pend_id_q) begin
        tx_start = 1'b1; tx_data = BYTE_ID; pend_id_d = 1'b0;
        last_d = BYTE_ID;
      end else if (pend_rep_q) begin
        tx_start = 1'b1; tx_data = last_q; pend_rep_d = 1'b0;
      end else if (!q_empty) begin
        q_pop = 1'b1;
        if (q_out.err) begin
          pend_err_d = 1'b1;
        end else begin
          pend_ack_d = 1'b1;
          if (q_out.data == BYTE_RESET)  pend_aa_d  = 1'b1;
          if (q_out.data == BYTE_RESEND) pend_rep_d = 1'b1;
        end
      end else if (in_valid_i) begin
        tx_start = 1'b1; tx_data = in_data_i; last_d = in_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_ack_q  <= 1'b0;
      pend_err_q  <= 1'b0;
      pend_aa_q   <= 1'b1;
      pend_id_q   <= 1'b0;
      pend_rep_q  <= 1'b0;
      last_q      <= BYTE_INIT;
      tx_strobe_o <= 1'b0;
      tx_byte_o   <= '0;
    end else begin
      pend_ack_q  <= pend_ack_d;
      pend_err_q  <= pend_err_d;
      pend_aa_q   <= pend_aa_d;
      pend_id_q   <= pend_id_d;
      pend_rep_q  <= pend_rep_d;
      last_q      <= last_d;
      tx_strobe_o <= tx_start;
      if (tx_start) tx_byte_o <= tx_data;
    end
  end

  assign cmd_valid_o = rx_valid;
  assign cmd_data_o  = rx_data;
endmodule

// File: rtl/ps2_dev_emu_chk.sv
module ps2_dev_emu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       in_ready_o,
  input logic       dev_clk_o,
  input logic       dev_dat_o,
  input logic       tx_strobe_o,
  input logic [7:0] tx_byte_o,
  input logic       cmd_valid_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (tx_strobe_o) seen_q <= 1'b1;
  end

  // R1
  frame_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |-> (!dev_dat_o && dev_clk_o));

  // R1
  data_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dev_dat_o) |-> dev_clk_o);

  // R1
  sample_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dev_clk_o) |-> $stable(dev_dat_o));

  // R2
  first_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_strobe_o && !seen_q) |-> (tx_byte_o == 8'hAA));

  // R3
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (tx_strobe_o && tx_byte_o == $past(in_data_i)));

  // R3
  strobe_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_o |=> !tx_strobe_o);

  // R8
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

bind ps2_dev_emu ps2_dev_emu_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .in_ready_o  (in_ready_o),
  .dev_clk_o   (dev_clk_o),
  .dev_dat_o   (dev_dat_o),
  .tx_strobe_o (tx_strobe_o),
  .tx_byte_o   (tx_byte_o),
  .cmd_valid_o (cmd_valid_o)
);

// File: tb/test_ps2_dev_emu.sv
`timescale 1ns/1ps
module test_ps2_dev_emu;
  localparam int BIT_CYC = 8;
  localparam int HOST_HALF = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_mouse = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       host_clk = 1'b1;
  logic       host_dat = 1'b1;
  logic       dev_clk, dev_dat, tx_strobe, cmd_valid;
  logic [7:0] tx_byte, cmd_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rx_log [0:511];
  logic [7:0] stb_log[0:511];
  logic [7:0] exp_log[0:511];
  logic [7:0] cmd_log[0:31];
  int rx_n = 0, stb_n = 0, exp_n = 0, cmd_n = 0, done_n = 0;

  always #2.5 clk = ~clk;

  ps2_dev_emu #(.BIT_CYC(BIT_CYC), .CMD_DEPTH(4)) i_ps2_dev_emu (
    .clk_i(clk), .rst_ni(rst_ni), .mode_mouse_i(mode_mouse),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .host_clk_i(host_clk), .host_dat_i(host_dat),
    .dev_clk_o(dev_clk), .dev_dat_o(dev_dat),
    .tx_strobe_o(tx_strobe), .tx_byte_o(tx_byte),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // device line decoder, sampled away from the active edge
  logic       p_clk = 1'b1, p_dat = 1'b1, viol = 1'b0;
  logic [10:0] bits;
  int bit_i = 0, cyc = 0;
  always @(negedge clk) begin
    if (!rst_ni) begin
      bit_i = 0; cyc = 0; viol = 1'b0;
    end else begin
      cyc++;
      if (dev_dat !== p_dat && !dev_clk) viol = 1'b1;  // R1 data moves only in high phase
      if (p_clk && !dev_clk) begin
        if (bit_i > 0 && cyc != BIT_CYC) viol = 1'b1;
        cyc = 0;
        bits[bit_i] = dev_dat;
        bit_i++;
        if (bit_i == 11) begin
          // R1 start 0, stop 1, odd parity, bit timing
          chk(!bits[0] && bits[10] && (^bits[9:1]) && !viol, "R1 frame",
              int'(bits), int'(bits[8:1]));
          rx_log[rx_n] = bits[8:1];
          rx_n++;
          bit_i = 0;
          viol = 1'b0;
        end
      end
      if (tx_strobe) begin stb_log[stb_n] = tx_byte; stb_n++; end
      if (cmd_valid) begin cmd_log[cmd_n] = cmd_data; cmd_n++; end
    end
    p_clk = dev_clk;
    p_dat = dev_dat;
  end

  task automatic expect_b(input logic [7:0] b);
    exp_log[exp_n] = b;
    exp_n++;
  endtask

  task automatic verify(input string req);
    int t = 0;
    while (rx_n < exp_n && t < 40000) begin @(negedge clk); t++; end
    repeat (300) @(negedge clk);
    chk(rx_n == exp_n, {req, " byte count"}, rx_n, exp_n);
    chk(stb_n == exp_n, {"R3 strobe count"}, stb_n, exp_n);
    for (int i = done_n; i < exp_n; i++) begin
      chk(rx_log[i] == exp_log[i], req, rx_log[i], exp_log[i]);
      chk(stb_log[i] == exp_log[i], "R3 strobe byte", stb_log[i], exp_log[i]);
    end
    done_n = exp_n;
    rx_n = exp_n;
    stb_n = exp_n;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic host_send(input logic [7:0] b, input bit bad_par);
    logic [10:0] f;
    f = {1'b1, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      host_dat = f[i];
      repeat (HOST_HALF) @(negedge clk);
      host_clk = 1'b0;
      repeat (HOST_HALF) @(negedge clk);
      host_clk = 1'b1;
    end
    host_dat = 1'b1;
  endtask

  task automatic do_reset(input logic mouse);
    @(negedge clk);
    rst_ni = 1'b0;
    mode_mouse = mouse;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(dev_clk && dev_dat, "R2 lines idle in reset", {dev_clk, dev_dat}, 3);
    chk(!tx_strobe && !cmd_valid && !in_ready, "R2 outputs quiet in reset",
        {tx_strobe, cmd_valid, in_ready}, 0);
    rst_ni = 1'b1;

    // R2 keyboard start-up: 0xAA only
    expect_b(8'hAA);
    verify("R2 keyboard init");

    // R3 sweep of every byte value through the stream
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v));
      expect_b(8'(v));
    end
    verify("R3 stream sweep");

    // R4 other command gets ack only; R8 command port
    c0 = cmd_n;
    host_send(8'hED, 1'b0);
    expect_b(8'hFA);
    verify("R4 ack");
    chk(cmd_n == c0 + 1 && cmd_log[c0] == 8'hED, "R8 cmd port", cmd_log[c0], 8'hED);

    // R6 resend replays last stream byte 0xFF, twice
    host_send(8'hFE, 1'b0);
    expect_b(8'hFA); expect_b(8'hFF);
    verify("R6 resend");
    host_send(8'hFE, 1'b0);
    expect_b(8'hFA); expect_b(8'hFF);
    verify("R6 resend repeat");

    // R7 bad parity: 0xFE only, nothing on command port
    c0 = cmd_n;
    host_send(8'h12, 1'b1);
    expect_b(8'hFE);
    verify("R7 bad parity");
    chk(cmd_n == c0, "R7 no cmd output", cmd_n, c0);
    host_send(8'hFE, 1'b0);
    expect_b(8'hFA); expect_b(8'hFF);
    verify("R6 error reply not stored");

    // R5 reset command, keyboard
    host_send(8'hFF, 1'b0);
    expect_b(8'hFA); expect_b(8'hAA);
    verify("R5 keyboard reset cmd");
    host_send(8'hFE, 1'b0);
    expect_b(8'hFA); expect_b(8'hAA);
    verify("R6 resend after init");

    // R9 command lands during a frame while the next stream byte waits
    c0 = cmd_n;
    send_byte(8'h5A);
    fork
      host_send(8'hF4, 1'b0);
      begin repeat (5) @(negedge clk); send_byte(8'h33); end
    join
    expect_b(8'h5A); expect_b(8'hFA); expect_b(8'h33);
    verify("R9 queued command");
    chk(cmd_n == c0 + 1 && cmd_log[c0] == 8'hF4, "R8 queued cmd port", cmd_log[c0], 8'hF4);

    // R2 mouse start-up
    do_reset(1'b1);
    expect_b(8'hAA); expect_b(8'h00);
    verify("R2 mouse init");

    // R5 reset command, mouse
    host_send(8'hFF, 1'b0);
    expect_b(8'hFA); expect_b(8'hAA); expect_b(8'h00);
    verify("R5 mouse reset cmd");
    host_send(8'hFE, 1'b0);
    expect_b(8'hFA); expect_b(8'h00);
    verify("R6 resend id byte");

    send_byte(8'h08);
    expect_b(8'h08);
    verify("R3 mouse stream");
    host_send(8'hFE, 1'b0);
    expect_b(8'hFA); expect_b(8'h08);
    verify("R6 resend mouse stream");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule